// File: doc/BRIEF.md
# Calibration Serial Port with Gated Pulse Counter

This block sits between a host register interface and a shared serial bus used for analog calibration. The bus carries one data-in line, one data-out line and one clock to a calibration EEPROM, a reference DAC and four trim-DAC devices. The host does not drive the serial clock itself. Each accepted access to the serial register produces exactly one clock pulse. On a write, the host supplies the outgoing data bit and a three-bit channel number. On a read, the block samples the returning data bit at the rising clock edge.

A read also starts a measurement. A five-bit counter is cleared and then counts rising edges of an asynchronous pulse input. The count window has a fixed length, so every read measures over the same time. When the window closes, the block reports four things in one byte: the count, a flag that shows the counter wrapped, the synchronized comparator level and the sampled data-out bit. A second register holds the active-high chip selects of the bus devices. While a pulse or a window is in progress, the block shows busy and drops any new access.

Top module: `cal_serial_port`

## Requirements
- R1: A write to register 0 (`acc_sel`=0) accepted while idle sets `ser_di` to `wdata[0]` and `chan_sel` to `wdata[3:1]`. Exactly one `ser_clk` pulse follows. The pulse rises SCK_HALF clock cycles after the accepting edge and stays high for SCK_HALF cycles.
- R2: `ser_di` does not change while `ser_clk` is high. Data is valid at the rising edge of the serial clock.
- R3: A read of register 0 produces exactly one `ser_clk` pulse. `rdata[7]` reports the level of `ser_do` at that pulse's rising edge.
- R4: A read of register 0 clears the counter. The counter then counts rising edges of `pulse_in` for a window of GATE_CYCLES cycles. `rdata[4:0]` reports the count modulo 32, with bit 0 as the LSB.
- R5: `rdata[5]` is 1 when the counter wrapped past 31 during the window, and 0 otherwise. The next read clears it.
- R6: `rdata[6]` reports the synchronized `cmp_in` level at the end of the window (1 = DAC voltage below the reference).
- R7: `rdata_valid` is high for exactly one cycle. That cycle is GATE_CYCLES clock cycles after the read was accepted. `rdata` then holds its value until the next read.
- R8: A write to register 1 (`acc_sel`=1) sets `chip_sel` to `wdata[5:0]`. The bits are bit 0 EEPROM, bit 1 reference DAC and bits 2 to 5 the trim devices. This write makes no clock pulse and does not set busy. A read of register 1 has no effect.
- R9: `busy` is high exactly while a clock pulse or a count window is in progress. Any access that arrives while `busy` is high is ignored.
- R10: After reset, `ser_clk`, `ser_di`, `chan_sel`, `chip_sel`, `busy`, `rdata` and `rdata_valid` are all zero.
- R11: `chan_sel` keeps its value across reads and across writes to register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | Register select: 0 = serial register, 1 = chip-select register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read result: {data-out, comparator, wrap flag, count[4:0]} |
| rdata_valid | output | 1 | One-cycle strobe when the read result is ready |
| busy | output | 1 | Clock pulse or count window in progress |
| ser_clk | output | 1 | Serial bus clock |
| ser_di | output | 1 | Serial data to the devices |
| ser_do | input | 1 | Serial data from the devices |
| cmp_in | input | 1 | Calibration comparator output, asynchronous |
| pulse_in | input | 1 | Pulse input counted during the window, asynchronous |
| chan_sel | output | 3 | Channel under calibration |
| chip_sel | output | 6 | Active-high device chip selects |

## Verification
The counter is tested with these pulse counts:
- Zero pulses, which shows that the read clears the counter.
- 31 and 32 pulses, which separate the last count without a wrap from the first count with a wrap.
- 45 pulses, which shows that the count keeps going past the wrap while the flag stays set.
- Random counts, always placed well inside the window.

The data-out and comparator levels are randomized on each read, so a bit swapped inside the result byte shows up. Writes to the serial register measure the position and width of the clock pulse in time. Writes, and the data and select values they carry, are also injected in the middle of a window to show that accesses are dropped while busy and cause no extra clock pulse.

// File: rtl/cal_serial_port.sv
`timescale 1ns/1ps
module cal_serial_port #(
  parameter int SCK_HALF    = 2,
  parameter int GATE_CYCLES = 200,
  parameter int CNT_W       = 5,
  parameter int CH_W        = 3,
  parameter int NUM_CS      = 6,
  parameter int DW          = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic                acc_sel,
  input  logic [DW-1:0]       wdata,
  output logic [CNT_W+2:0]    rdata,
  output logic                rdata_valid,
  output logic                busy,
  output logic                ser_clk,
  output logic                ser_di,
  input  logic                ser_do,
  input  logic                cmp_in,
  input  logic                pulse_in,
  output logic [CH_W-1:0]     chan_sel,
  output logic [NUM_CS-1:0]   chip_sel
);
  localparam int PH_W = $clog2(GATE_CYCLES + 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(SCK_HALF - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(2 * SCK_HALF - 1);
  localparam logic [PH_W-1:0] PH_GATE = PH_W'(GATE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_t;

  st_t              st;
  logic [PH_W-1:0]  ph;
  logic [2:0]       pin_s;
  logic [1:0]       cmp_s;
  logic [CNT_W-1:0] cnt;
  logic             ovf, sdo_q, cmp_q;

  wire acc_ok   = acc_valid && (st == S_IDLE);
  wire wr_ser   = acc_ok &&  acc_write && !acc_sel;
  wire wr_cs    = acc_ok &&  acc_write &&  acc_sel;
  wire rd_ser   = acc_ok && !acc_write && !acc_sel;
  wire pin_edge = pin_s[1] & ~pin_s[2];
  wire wr_end   = (st == S_WR) && (ph == PH_FALL);
  wire rd_end   = (st == S_RD) && (ph == PH_GATE);
  wire sck_on   = (st != S_IDLE) && (ph == PH_RISE);
  wire sck_off  = (st != S_IDLE) && (ph == PH_FALL);

  assign busy  = (st != S_IDLE);
  assign rdata = {sdo_q, cmp_q, ovf, cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= '0;
      pin_s       <= '0;
      cmp_s       <= '0;
      cnt         <= '0;
      ovf         <= 1'b0;
      sdo_q       <= 1'b0;
      cmp_q       <= 1'b0;
      rdata_valid <= 1'b0;
      ser_clk     <= 1'b0;
      ser_di      <= 1'b0;
      chan_sel    <= '0;
      chip_sel    <= '0;
    end else begin
      pin_s       <= {pin_s[1:0], pulse_in};
      cmp_s       <= {cmp_s[0], cmp_in};
      rdata_valid <= rd_end;

      if (wr_ser) begin
        ser_di   <= wdata[0];
        chan_sel <= wdata[CH_W:1];
      end
      if (wr_cs) chip_sel <= wdata[NUM_CS-1:0];

      if (sck_on)       ser_clk <= 1'b1;
      else if (sck_off) ser_clk <= 1'b0;
      if (sck_on && st == S_RD) sdo_q <= ser_do;

      if (rd_ser) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (st == S_RD && pin_edge) begin
        cnt <= cnt + 1'b1;
        if (&cnt) ovf <= 1'b1;
      end
      if (rd_end) cmp_q <= cmp_s[1];

      case (st)
        S_IDLE: begin
          ph <= '0;
          if (wr_ser)      st <= S_WR;
          else if (rd_ser) st <= S_RD;
        end
        S_WR: if (wr_end) begin st <= S_IDLE; ph <= '0; end else ph <= ph + 1'b1;
        S_RD: if (rd_end) begin st <= S_IDLE; ph <= '0; end else ph <= ph + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ser_clk); // R9
  AST_DI_STABLE: assert property (@(posedge clk) disable iff (!rst_n) ser_clk |-> $stable(ser_di)); // R2
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n) rdata_valid |=> !rdata_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rdata_valid |-> !busy); // R7
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(busy) |-> $stable(chip_sel)); // R9
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(busy) |-> $stable(chan_sel)); // R9
endmodule

// File: tb/tb_cal_serial_port.sv
`timescale 1ns/1ps
module tb_cal_serial_port;
  localparam int SH   = 2;
  localparam int GATE = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_valid, busy, ser_clk, ser_di;
  logic ser_do = 1'b0, cmp_in = 1'b0, pulse_in = 1'b0;
  logic [2:0] chan_sel;
  logic [5:0] chip_sel;

  cal_serial_port #(.SCK_HALF(SH), .GATE_CYCLES(GATE)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
    .busy(busy), .ser_clk(ser_clk), .ser_di(ser_di), .ser_do(ser_do),
    .cmp_in(cmp_in), .pulse_in(pulse_in), .chan_sel(chan_sel), .chip_sel(chip_sel));

  always #10 clk = ~clk;

  int  n_tests = 0, n_fail = 0, cyc = 0, rises = 0;
  time rise_t = 0, fall_t = 0;
  logic last_di = 1'b0;
  logic [2:0] exp_chan = '0;
  logic [5:0] exp_cs = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge ser_clk) begin rises = rises + 1; rise_t = $time; last_di = ser_di; end
  always @(negedge ser_clk) fall_t = $time;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int n, input bit sdo, input bit cmp);
    logic [4:0] c = 5'(n);
    return {sdo, cmp, (n >= 32), c};
  endfunction

  task automatic access(input bit wr, input bit sel, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_sel = sel; wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic write_ser(input logic [7:0] d);
    int r0 = rises;
    time tacc;
    access(1'b1, 1'b0, d);
    tacc = $time - 10;
    chk(busy, "R9 busy during write pulse", busy, 1);
    while (busy) @(negedge clk);
    exp_chan = d[3:1];
    chk(rises == r0 + 1, "R1 single pulse per write", rises - r0, 1);
    chk(rise_t == tacc + SH * 20, "R1 rise position", int'(rise_t - tacc), SH * 20);
    chk(fall_t - rise_t == SH * 20, "R1 high width", int'(fall_t - rise_t), SH * 20);
    chk(last_di == d[0], "R1/R2 data at rising edge", last_di, d[0]);
    chk(chan_sel == exp_chan, "R1 channel select", chan_sel, exp_chan);
  endtask

  task automatic write_cs(input logic [7:0] d);
    int r0 = rises;
    logic [2:0] ch0 = chan_sel;
    access(1'b1, 1'b1, d);
    exp_cs = d[5:0];
    chk(!busy, "R8 chip-select write not busy", busy, 0);
    chk(chip_sel == exp_cs, "R8 chip selects", chip_sel, exp_cs);
    chk(rises == r0, "R8 no clock pulse", rises - r0, 0);
    chk(chan_sel == ch0, "R11 chan_sel kept on cs write", chan_sel, ch0);
  endtask

  task automatic read_cs();
    int r0 = rises;
    bit seen = 0;
    access(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 6; i++) begin
      if (rdata_valid || busy) seen = 1;
      @(negedge clk);
    end
    chk(!seen && rises == r0 && chip_sel == exp_cs, "R8 cs read ignored", seen, 0);
  endtask

  task automatic read_ser(input int n, input bit sdo, input bit cmp, input bit poke);
    int r0 = rises, c0;
    logic [7:0] e = exp_rd(n, sdo, cmp);
    ser_do = sdo; cmp_in = cmp;
    access(1'b0, 1'b0, 8'($urandom));
    c0 = cyc;
    chk(busy, "R9 busy in window", busy, 1);
    if (poke) begin
      acc_valid = 1'b1; acc_write = 1'b1; acc_sel = 1'b0; wdata = {4'h0, ~exp_chan, 1'b1};
      @(negedge clk);
      acc_sel = 1'b1; wdata = {2'b00, ~exp_cs};
      @(negedge clk);
      acc_valid = 1'b0;
    end
    repeat (5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1; repeat (2) @(negedge clk);
      pulse_in = 1'b0; repeat (2) @(negedge clk);
    end
    while (!rdata_valid && cyc < c0 + GATE + 10) @(negedge clk);
    chk(rdata_valid && cyc == c0 + GATE, "R7 result strobe timing", cyc - c0, GATE);
    chk(rdata[4:0] == e[4:0], "R4 pulse count", rdata[4:0], e[4:0]);
    chk(rdata[5] == e[5], "R5 wrap flag", rdata[5], e[5]);
    chk(rdata[6] == cmp, "R6 comparator bit", rdata[6], cmp);
    chk(rdata[7] == sdo, "R3 data-out bit", rdata[7], sdo);
    chk(rises == r0 + 1, "R3 single pulse per read", rises - r0, 1);
    chk(chan_sel == exp_chan, "R11 chan_sel kept over read", chan_sel, exp_chan);
    if (poke) chk(chip_sel == exp_cs, "R9 access during busy ignored", chip_sel, exp_cs);
    @(negedge clk);
    chk(!rdata_valid, "R7 strobe one cycle", rdata_valid, 0);
    repeat (3) @(negedge clk);
    chk(rdata == e, "R7 result holds", rdata, e);
  endtask

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({ser_clk, ser_di, chan_sel, chip_sel, busy, rdata, rdata_valid} == '0,
        "R10 reset state", {ser_clk, ser_di, chan_sel, chip_sel, busy, rdata, rdata_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    write_ser(8'h0B);
    write_ser(8'h04);
    write_cs(8'h21);
    read_cs();
    read_ser(0, 1'b1, 1'b0, 1'b0);
    read_ser(31, 1'b0, 1'b1, 1'b0);
    read_ser(32, 1'b1, 1'b1, 1'b0);
    read_ser(45, 1'b0, 1'b0, 1'b0);
    read_ser(7, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 30; k++) begin
      case ($urandom % 3)
        0: write_ser(8'($urandom));
        1: write_cs(8'($urandom));
        default: read_ser(int'($urandom % 46), 1'($urandom), 1'($urandom), 1'($urandom));
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule